// File: doc/BRIEF.md
# Attribute Controller Port Interface

This block is the host-facing register file of a display attribute controller. A host reaches it over a byte-wide I/O bus with a two-bit port select and separate write and read strobes. One shared port takes both the register index and the register data. An internal phase bit tells the block which of the two the next write is. A read of a separate clear port puts the phase back to index, so software can always resynchronise before it starts an access sequence.

Each index write also latches a video-enable bit. This bit blanks the display when it is zero and restores output when it is one. Software drops it while it reloads the colour table and raises it again afterwards. The block holds 21 byte-wide registers. Sixteen of them are palette entries. Two are also brought out on their own pins: the mode-control register and the border (overscan) colour register. Every register is also available on one flat vector for the display pipeline, which is not part of this block.

Top module: `attr_ctl_port`

## Requirements
- R1: After reset the phase is index, video_en is 0, the stored index is 0 and all 21 registers read as 0.
- R2: A write to port 0 (the shared port) in the index phase stores bits 4:0 as the register index and bit 5 as video_en, then moves the phase to data.
- R3: A write to port 0 in the data phase stores the byte in the register chosen by the stored index, then returns the phase to index.
- R4: A read of port 2 (the clear port) forces the phase to index and returns 0, so the following port 0 write is taken as an index.
- R5: A read of port 1 (the read-data port) returns the register chosen by the stored index and leaves the phase unchanged.
- R6: Indices 0x15 to 0x1F select no register. A data write to them changes no register but still returns the phase to index, and a port 1 read returns 0.
- R7: A read of port 0 returns the index byte, with the index in bits 4:0, video_en in bit 5 and zeros elsewhere, and changes no state. bus_rdata is 0 whenever bus_rd is low.
- R8: mode_ctrl mirrors register 0x10 and border_color mirrors register 0x11. Register i appears at regs_flat[8i+7:8i].
- R9: video_en changes only on an index-phase write to port 0. Data writes leave it as it was.
- R10: When bus_wr and bus_rd are both high, only the write takes effect. Port 2 does not clear the phase, and bus_rdata is 0.
- R11: Bits 7:6 of an index write are discarded and read back as 0.
- R12: Writes to ports 1, 2 and 3 change no state, and a read of port 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_port | input | 2 | Port select: 0 shared index/data, 1 read data, 2 phase clear, 3 unused |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational while bus_rd is high |
| video_en | output | 1 | Display enable latched from index writes |
| mode_ctrl | output | 8 | Mode-control register (index 0x10) |
| border_color | output | 8 | Border colour register (index 0x11) |
| regs_flat | output | 168 | All registers, register i in bits 8i+7:8i |

## Verification
The bench sweeps all 32 index values with video_en set. It writes a computed data byte to each index, then reads every index back and compares against a bench model. A design that decodes out-of-range indices would alias 0x15 to 0x1F onto real registers or return stale data. A design whose read-data port toggles the phase would turn the next intended data write into an index. A design that did not clear on a port 2 read, or that cleared on a write to port 2, or on a port 2 read made in the same cycle as a write, would misplace the next byte. The bench also checks that data writes leave video_en alone and that the two high bits of an index byte are dropped.

// File: rtl/attr_ctl_pkg.sv
package attr_ctl_pkg;
   // Port select encoding on the host bus.
   typedef enum logic [1:0] {
      PORT_SHARED = 2'd0,
      PORT_RDATA  = 2'd1,
      PORT_FFCLR  = 2'd2,
      PORT_SPARE  = 2'd3
   } port_e;
endpackage

// File: rtl/attr_phase_ff.sv
// Index/data phase bit: toggles on each shared-port write, cleared by a clear-port read.
module attr_phase_ff (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_shared,
   input  logic clr_rd,
   output logic phase_data
);
   always_ff @(posedge clk) begin
      if (!rst_n)
         phase_data <= 1'b0;
      else if (clr_rd)
         phase_data <= 1'b0;
      else if (wr_shared)
         phase_data <= ~phase_data;
   end
endmodule

// File: rtl/attr_index_reg.sv
// Holds the selected register index and the video-enable bit.
module attr_index_reg #(
   parameter int DATA_W  = 8,
   parameter int IDX_W   = 5,
   parameter int VEN_BIT = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] wdata,
   output logic [IDX_W-1:0]  idx,
   output logic              ven
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx <= '0;
         ven <= 1'b0;
      end else if (load) begin
         idx <= wdata[IDX_W-1:0];
         ven <= wdata[VEN_BIT];
      end
   end
endmodule

// File: rtl/attr_regfile.sv
// NUM_REGS byte registers, one write decoder each.
module attr_regfile #(
   parameter int DATA_W   = 8,
   parameter int IDX_W    = 5,
   parameter int NUM_REGS = 21,
   localparam int REGS_W  = NUM_REGS * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [IDX_W-1:0]  idx,
   input  logic [DATA_W-1:0] wdata,
   output logic [REGS_W-1:0] regs_flat
);
   for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      logic [DATA_W-1:0] q;
      logic              hit;
      assign hit = we && (idx == IDX_W'(g));
      always_ff @(posedge clk) begin
         if (!rst_n)
            q <= '0;
         else if (hit)
            q <= wdata;
      end
      assign regs_flat[g*DATA_W +: DATA_W] = q;
   end
endmodule

// File: rtl/attr_read_mux.sv
// Combinational read-back path for the three readable ports.
module attr_read_mux
   import attr_ctl_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int IDX_W    = 5,
   parameter int VEN_BIT  = 5,
   parameter int NUM_REGS = 21,
   localparam int REGS_W  = NUM_REGS * DATA_W
) (
   input  logic              rd_en,
   input  logic [1:0]        port,
   input  logic [IDX_W-1:0]  idx,
   input  logic              ven,
   input  logic [REGS_W-1:0] regs_flat,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] index_byte;
   logic [DATA_W-1:0] reg_sel;

   always_comb begin
      index_byte              = '0;
      index_byte[IDX_W-1:0]   = idx;
      index_byte[VEN_BIT]     = ven;
   end

   // Out-of-range indices match no entry and leave reg_sel at zero.
   always_comb begin
      reg_sel = '0;
      for (int k = 0; k < NUM_REGS; k++) begin
         if (idx == IDX_W'(k))
            reg_sel = regs_flat[k*DATA_W +: DATA_W];
      end
   end

   always_comb begin
      rdata = '0;
      if (rd_en) begin
         if (port == PORT_SHARED)
            rdata = index_byte;
         else if (port == PORT_RDATA)
            rdata = reg_sel;
      end
   end
endmodule

// File: rtl/attr_ctl_port.sv
module attr_ctl_port
   import attr_ctl_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int IDX_W      = 5,
   parameter int VEN_BIT    = 5,
   parameter int NUM_REGS   = 21,
   parameter int MODE_IDX   = 16,
   parameter int BORDER_IDX = 17,
   localparam int REGS_W    = NUM_REGS * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        bus_port,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              video_en,
   output logic [DATA_W-1:0] mode_ctrl,
   output logic [DATA_W-1:0] border_color,
   output logic [REGS_W-1:0] regs_flat
);
   // Elaboration-time parameter checks.
   if (VEN_BIT < IDX_W || VEN_BIT >= DATA_W) begin : g_bad_ven
      $error("enable bit must sit above the index field inside the byte");
   end
   if (NUM_REGS < 1 || NUM_REGS > (1 << IDX_W)) begin : g_bad_regs
      $error("register count does not fit the index field");
   end
   if (MODE_IDX >= NUM_REGS || BORDER_IDX >= NUM_REGS) begin : g_bad_taps
      $error("tapped register index outside the register file");
   end

   logic             phase_data;
   logic [IDX_W-1:0] idx_q;
   logic             wr_shared;
   logic             rd_eff;
   logic             clr_rd;

   // A write in the same cycle suppresses every read side effect.
   assign wr_shared = bus_wr && (bus_port == PORT_SHARED);
   assign rd_eff    = bus_rd && !bus_wr;
   assign clr_rd    = rd_eff && (bus_port == PORT_FFCLR);

   attr_phase_ff u_phase (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_shared  (wr_shared),
      .clr_rd     (clr_rd),
      .phase_data (phase_data)
   );

   attr_index_reg #(.DATA_W(DATA_W), .IDX_W(IDX_W), .VEN_BIT(VEN_BIT)) u_index (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (wr_shared && !phase_data),
      .wdata (bus_wdata),
      .idx   (idx_q),
      .ven   (video_en)
   );

   attr_regfile #(.DATA_W(DATA_W), .IDX_W(IDX_W), .NUM_REGS(NUM_REGS)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .we        (wr_shared && phase_data),
      .idx       (idx_q),
      .wdata     (bus_wdata),
      .regs_flat (regs_flat)
   );

   attr_read_mux #(.DATA_W(DATA_W), .IDX_W(IDX_W), .VEN_BIT(VEN_BIT),
                   .NUM_REGS(NUM_REGS)) u_rmux (
      .rd_en     (rd_eff),
      .port      (bus_port),
      .idx       (idx_q),
      .ven       (video_en),
      .regs_flat (regs_flat),
      .rdata     (bus_rdata)
   );

   assign mode_ctrl    = regs_flat[MODE_IDX*DATA_W +: DATA_W];
   assign border_color = regs_flat[BORDER_IDX*DATA_W +: DATA_W];
endmodule

// File: rtl/attr_ctl_port_chk.sv
module attr_ctl_port_chk #(
   parameter int DATA_W   = 8,
   parameter int IDX_W    = 5,
   parameter int NUM_REGS = 21
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        bus_port,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              video_en,
   input logic              phase_data,
   input logic [IDX_W-1:0]  idx
);
   localparam logic [IDX_W:0] LIMIT = NUM_REGS[IDX_W:0];

   a_r2_index_then_data: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_port == 2'd0 && !phase_data) |=> phase_data);

   a_r3_data_then_index: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_port == 2'd0 && phase_data) |=> !phase_data);

   a_r4_clear_read: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !bus_wr && bus_port == 2'd2) |=> !phase_data);

   a_r5_rdata_keeps_phase: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !bus_wr && bus_port == 2'd1) |=> $stable(phase_data));

   a_r6_oob_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !bus_wr && bus_port == 2'd1 && {1'b0, idx} >= LIMIT) |-> bus_rdata == '0);

   a_r7_idle_rdata_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |-> bus_rdata == '0);

   a_r9_ven_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && bus_port == 2'd0 && !phase_data) |=> $stable(video_en));
endmodule

bind attr_ctl_port attr_ctl_port_chk #(
   .DATA_W(DATA_W), .IDX_W(IDX_W), .NUM_REGS(NUM_REGS)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_port   (bus_port),
   .bus_wr     (bus_wr),
   .bus_rd     (bus_rd),
   .bus_rdata  (bus_rdata),
   .video_en   (video_en),
   .phase_data (phase_data),
   .idx        (idx_q)
);

// File: tb/test_attr_ctl_port.sv
`timescale 1ns/1ps
module test_attr_ctl_port;
   localparam int NR = 21;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [1:0]   bus_port = 2'd0;
   logic         bus_wr = 1'b0;
   logic         bus_rd = 1'b0;
   logic [7:0]   bus_wdata = 8'd0;
   logic [7:0]   bus_rdata;
   logic         video_en;
   logic [7:0]   mode_ctrl;
   logic [7:0]   border_color;
   logic [NR*8-1:0] regs_flat;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // Bench model of the register file.
   logic [7:0] m_regs [NR];
   logic [4:0] m_idx;
   logic       m_ven;
   logic       m_data;

   always #4 clk = ~clk;

   attr_ctl_port i_attr_ctl_port (
      .clk(clk), .rst_n(rst_n), .bus_port(bus_port), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .video_en(video_en), .mode_ctrl(mode_ctrl), .border_color(border_color),
      .regs_flat(regs_flat)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_read(input logic [1:0] p);
      if (p == 2'd0) return {2'b00, m_ven, m_idx};
      if (p == 2'd1) return (m_idx < 5'(NR)) ? m_regs[m_idx] : 8'h00;
      return 8'h00;
   endfunction

   task automatic model_write(input logic [1:0] p, input logic [7:0] d);
      if (p == 2'd0) begin
         if (!m_data) begin
            m_idx = d[4:0];
            m_ven = d[5];
            m_data = 1'b1;
         end else begin
            if (m_idx < 5'(NR)) m_regs[m_idx] = d;
            m_data = 1'b0;
         end
      end
   endtask

   task automatic wr_port(input logic [1:0] p, input logic [7:0] d);
      @(negedge clk);
      bus_port = p; bus_wdata = d; bus_wr = 1'b1; bus_rd = 1'b0;
      @(negedge clk);
      bus_wr = 1'b0;
      model_write(p, d);
   endtask

   task automatic rd_chk(input logic [1:0] p, input string tag);
      logic [7:0] e;
      e = exp_read(p);
      @(negedge clk);
      bus_port = p; bus_rd = 1'b1; bus_wr = 1'b0;
      #1 check(tag, {24'd0, bus_rdata}, {24'd0, e});
      @(negedge clk);
      bus_rd = 1'b0;
      if (p == 2'd2) m_data = 1'b0;
   endtask

   task automatic both_port(input logic [1:0] p, input logic [7:0] d, input string tag);
      @(negedge clk);
      bus_port = p; bus_wdata = d; bus_wr = 1'b1; bus_rd = 1'b1;
      #1 check(tag, {24'd0, bus_rdata}, 32'd0);
      @(negedge clk);
      bus_wr = 1'b0; bus_rd = 1'b0;
      model_write(p, d);
   endtask

   task automatic check_all_regs(input string tag);
      for (int k = 0; k < NR; k++)
         check(tag, {24'd0, regs_flat[k*8 +: 8]}, {24'd0, m_regs[k]});
   endtask

   initial begin
      for (int k = 0; k < NR; k++) m_regs[k] = 8'h00;
      m_idx = 5'd0; m_ven = 1'b0; m_data = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      check("R1 video_en", {31'd0, video_en}, 32'd0);
      check_all_regs("R1 regs");
      rd_chk(2'd0, "R1 index byte after reset");

      // R2, R8: index 0x11 with enable, then border data
      wr_port(2'd0, 8'h31);
      check("R2 video_en set", {31'd0, video_en}, 32'd1);
      rd_chk(2'd0, "R2 index readback");
      wr_port(2'd0, 8'hA5);
      check("R3 R8 border_color", {24'd0, border_color}, 32'hA5);
      wr_port(2'd0, 8'h10);
      check("R2 video_en cleared", {31'd0, video_en}, 32'd0);
      wr_port(2'd0, 8'h5C);
      check("R8 mode_ctrl", {24'd0, mode_ctrl}, 32'h5C);

      // R3, R4, R6: sweep every index value
      for (int i = 0; i < 32; i++) begin
         rd_chk(2'd2, "R4 clear port reads zero");
         wr_port(2'd0, 8'(i) | 8'h20);
         wr_port(2'd0, 8'((i * 29 + 3) & 8'hFF));
      end
      check_all_regs("R3 R6 sweep contents");

      // R5, R6, R7: read back every index; port 1 reads keep the data phase
      for (int i = 0; i < 32; i++) begin
         rd_chk(2'd2, "R4 clear before index");
         wr_port(2'd0, 8'(i) | 8'h20);
         rd_chk(2'd1, "R5 R6 register readback");
         rd_chk(2'd1, "R5 repeated readback");
         rd_chk(2'd0, "R7 index byte");
         wr_port(2'd0, 8'(i) ^ 8'h5A);
      end
      check_all_regs("R5 data phase held after reads");

      // R6: out-of-range data write still returns to index phase
      wr_port(2'd0, 8'h1F);
      wr_port(2'd0, 8'hFF);
      check_all_regs("R6 oob write ignored");
      wr_port(2'd0, 8'h02);
      wr_port(2'd0, 8'h99);
      check("R6 next write was index", {24'd0, regs_flat[2*8 +: 8]}, 32'h99);

      // R4: clear read in data phase
      wr_port(2'd0, 8'h03);
      rd_chk(2'd2, "R4 clear port");
      wr_port(2'd0, 8'h24);
      rd_chk(2'd0, "R4 following write taken as index");

      // R10: write and read together; clear-port read suppressed
      wr_port(2'd0, 8'h44);   // data to index 4, phase back to index
      both_port(2'd2, 8'h00, "R10 rdata zero with write");
      both_port(2'd0, 8'h2B, "R10 rdata zero with shared write");
      wr_port(2'd0, 8'h6E);
      check("R10 write landed as data", {24'd0, regs_flat[11*8 +: 8]}, 32'h6E);

      // R11: high bits of index dropped
      wr_port(2'd0, 8'hC7);
      rd_chk(2'd0, "R11 index high bits");
      check("R11 video_en", {31'd0, video_en}, 32'd0);

      // R12: writes to other ports ignored, port 3 reads zero
      wr_port(2'd1, 8'hEE);
      wr_port(2'd2, 8'hEE);
      wr_port(2'd3, 8'hEE);
      rd_chk(2'd3, "R12 spare port reads zero");
      rd_chk(2'd1, "R12 register untouched");
      wr_port(2'd0, 8'h12);
      check("R12 still in data phase", {24'd0, regs_flat[7*8 +: 8]}, 32'h12);

      // R9: data writes leave video_en alone
      wr_port(2'd0, 8'h28);
      wr_port(2'd0, 8'h00);
      check("R9 video_en after data write", {31'd0, video_en}, 32'd1);
      check_all_regs("R9 final contents");

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule